// File: doc/BRIEF.md
# Single-Wire Debug Sync Responder

This block sits on the target end of a single-wire, open-drain debug link. It samples the shared line and treats a low period longer than any normal bit as a speed-calibration request. It then answers with a low pulse of fixed length, timed by its own debug clock. The host measures that pulse and derives the target's clock rate for later traffic. The block owns the pin only while it is answering. Decoding of normal bits belongs to other logic.

After a request is recognised, the responder waits for the host to let the line rise. It then waits a short guard interval, so the host can stop its own rising-edge assist. Next it pulls the line low for a fixed number of cycles and drives it high for one cycle to sharpen the rising edge. Finally it releases the pin to high impedance. The line sample can pass through a parameterised resynchroniser; this adds a fixed latency before the guard starts.

Top module: `sync_responder`

## Requirements
- R1: While reset is asserted, `drv_en` and `busy` are 0. Reset is asynchronous, so `drv_en` falls without waiting for a clock edge.
- R2: A low period shorter than `DET_CYCLES` sampled cycles starts no reply: `busy` and `drv_en` stay 0.
- R3: A low period of at least `DET_CYCLES` sampled cycles, followed by the line going high, starts a reply.
- R4: While the line is still held low after a request has been recognised, the block does not drive the pin and `busy` stays 0.
- R5: The first cycle with `drv_en`=1 comes `SYNC_STAGES + 1 + GUARD_CYCLES` clock edges after the first edge at which the input line is high. This latency includes the guard interval of exactly `GUARD_CYCLES`.
- R6: The reply drives `drv_en`=1 and `drv_val`=0 for exactly `REPLY_CYCLES` consecutive cycles.
- R7: Directly after the low phase, the block drives `drv_en`=1 and `drv_val`=1 for exactly one cycle. In the next cycle `drv_en` is 0.
- R8: Line activity during the guard interval or the reply does not change the reply's timing.
- R9: `busy` is 1 for exactly `GUARD_CYCLES + REPLY_CYCLES + 1` cycles per reply and is 1 whenever `drv_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Sampled level of the shared debug line |
| drv_en | output | 1 | 1 = block drives the pin, 0 = high impedance |
| drv_val | output | 1 | Level driven when `drv_en` is 1 (0 otherwise) |
| busy | output | 1 | Guard interval or reply in progress |

## Verification
The bench builds the block with a detection threshold of 8 cycles, a guard of 4, a reply of 16 and two resynchroniser stages. These short values let dozens of random low periods cover both sides of the threshold, including the exact values 7 and 8. The resynchroniser latency also shows up in every measured reply. The bench models the open-drain line as a wired AND of host and target. The block therefore sees its own low pulse and the host's glitches, and the bench checks that it ignores both.

// File: rtl/sync_responder_pkg.sv
package sync_responder_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_ARMED   = 3'd1,
      ST_GUARD   = 3'd2,
      ST_LOW     = 3'd3,
      ST_SPEEDUP = 3'd4
   } resp_state_t;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/line_sampler.sv
module line_sampler #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   output logic line_s
);

   generate
      if (STAGES == 0) begin : g_direct
         assign line_s = line_raw;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], line_raw} & {STAGES{1'b1}};
         end
         assign line_s = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/low_detector.sv
module low_detector #(
   parameter int unsigned DET_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic line_s,
   output logic hit
);

   localparam int unsigned DW = $clog2(DET_CYCLES + 1);
   localparam logic [DW-1:0] LAST = DW'(DET_CYCLES - 1);

   logic [DW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 run_q <= '0;
      else if (!enable || line_s) run_q <= '0;
      else if (run_q != LAST)     run_q <= run_q + 1'b1;
   end

   assign hit = enable && !line_s && (run_q == LAST);

endmodule

// File: rtl/reply_sequencer.sv
module reply_sequencer
   import sync_responder_pkg::*;
#(
   parameter int unsigned GUARD_CYCLES = 16,
   parameter int unsigned REPLY_CYCLES = 128
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_hit,
   input  logic        line_s,
   output resp_state_t state
);

   localparam int unsigned TW = $clog2(max3(GUARD_CYCLES, REPLY_CYCLES, 2) + 1);
   localparam logic [TW-1:0] GUARD_LAST = TW'(GUARD_CYCLES - 1);
   localparam logic [TW-1:0] REPLY_LAST = TW'(REPLY_CYCLES - 1);

   resp_state_t   state_q, state_d;
   logic [TW-1:0] tick_q, tick_d;

   always_comb begin
      state_d = state_q;
      tick_d  = tick_q;
      unique case (state_q)
         ST_IDLE: begin
            tick_d = '0;
            if (req_hit) state_d = ST_ARMED;
         end
         ST_ARMED: begin
            tick_d = '0;
            if (line_s) state_d = ST_GUARD;
         end
         ST_GUARD: begin
            if (tick_q == GUARD_LAST) begin
               state_d = ST_LOW;
               tick_d  = '0;
            end else begin
               tick_d = tick_q + 1'b1;
            end
         end
         ST_LOW: begin
            if (tick_q == REPLY_LAST) begin
               state_d = ST_SPEEDUP;
               tick_d  = '0;
            end else begin
               tick_d = tick_q + 1'b1;
            end
         end
         ST_SPEEDUP: begin
            state_d = ST_IDLE;
            tick_d  = '0;
         end
         default: begin
            state_d = ST_IDLE;
            tick_d  = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tick_q  <= '0;
      end else begin
         state_q <= state_d;
         tick_q  <= tick_d;
      end
   end

   assign state = state_q;

endmodule

// File: rtl/pin_stage.sv
module pin_stage
   import sync_responder_pkg::*;
(
   input  resp_state_t state,
   output logic        drv_en,
   output logic        drv_val,
   output logic        busy
);

   always_comb begin
      drv_en  = 1'b0;
      drv_val = 1'b0;
      busy    = 1'b0;
      unique case (state)
         ST_GUARD:   busy = 1'b1;
         ST_LOW:     begin busy = 1'b1; drv_en = 1'b1; end
         ST_SPEEDUP: begin busy = 1'b1; drv_en = 1'b1; drv_val = 1'b1; end
         default:    ;
      endcase
   end

endmodule

// File: rtl/sync_responder.sv
module sync_responder
   import sync_responder_pkg::*;
#(
   parameter int unsigned DET_CYCLES   = 64,
   parameter int unsigned GUARD_CYCLES = 16,
   parameter int unsigned REPLY_CYCLES = 128,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic drv_en,
   output logic drv_val,
   output logic busy
);

   if (DET_CYCLES < 2) begin : g_bad_det
      $error("DET_CYCLES must be at least 2");
   end
   if (GUARD_CYCLES < 1) begin : g_bad_guard
      $error("GUARD_CYCLES must be at least 1");
   end
   if (REPLY_CYCLES < 1) begin : g_bad_reply
      $error("REPLY_CYCLES must be at least 1");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must not exceed 4");
   end

   logic        line_s;
   logic        req_hit;
   resp_state_t state;

   line_sampler #(.STAGES(SYNC_STAGES)) i_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_raw (line_in),
      .line_s   (line_s)
   );

   low_detector #(.DET_CYCLES(DET_CYCLES)) i_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (state == ST_IDLE),
      .line_s (line_s),
      .hit    (req_hit)
   );

   reply_sequencer #(
      .GUARD_CYCLES (GUARD_CYCLES),
      .REPLY_CYCLES (REPLY_CYCLES)
   ) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_hit (req_hit),
      .line_s  (line_s),
      .state   (state)
   );

   pin_stage i_pin (
      .state   (state),
      .drv_en  (drv_en),
      .drv_val (drv_val),
      .busy    (busy)
   );

endmodule

// File: rtl/sync_responder_chk.sv
module sync_responder_chk #(
   parameter int unsigned GUARD_CYCLES = 16,
   parameter int unsigned REPLY_CYCLES = 128
) (
   input logic clk,
   input logic rst_n,
   input logic drv_en,
   input logic drv_val,
   input logic busy
);

   localparam int unsigned CW = $clog2(GUARD_CYCLES + REPLY_CYCLES + 4);

   logic [CW-1:0] low_run, guard_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run   <= '0;
         guard_run <= '0;
      end else begin
         low_run   <= (drv_en && !drv_val) ? low_run + 1'b1 : '0;
         guard_run <= (busy && !drv_en) ? guard_run + 1'b1 : '0;
      end
   end

   a_r1_quiet_in_reset: assert property (@(posedge clk)
      !rst_n |-> (!drv_en && !busy));

   a_r9_drive_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |-> busy);

   a_r7_release_after_high: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en && drv_val) |=> !drv_en);

   a_r6_low_length: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en && drv_val) |-> (low_run == CW'(REPLY_CYCLES)));

   a_r5_guard_length: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_en) |-> (guard_run == CW'(GUARD_CYCLES)));

   a_r7_high_follows_low: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en && drv_val) |-> $past(drv_en && !drv_val));

endmodule

bind sync_responder sync_responder_chk #(
   .GUARD_CYCLES (GUARD_CYCLES),
   .REPLY_CYCLES (REPLY_CYCLES)
) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .drv_en  (drv_en),
   .drv_val (drv_val),
   .busy    (busy)
);

// File: tb/test_sync_responder.sv
module test_sync_responder;

   localparam int unsigned DET   = 8;
   localparam int unsigned GUARD = 4;
   localparam int unsigned REPLY = 16;
   localparam int unsigned SYNC  = 2;
   localparam int unsigned LIMIT = SYNC + GUARD + REPLY + 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_low = 1'b0;
   logic line_in, drv_en, drv_val, busy;
   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   assign line_in = host_low ? 1'b0 : ((drv_en && !drv_val) ? 1'b0 : 1'b1);

   sync_responder #(
      .DET_CYCLES   (DET),
      .GUARD_CYCLES (GUARD),
      .REPLY_CYCLES (REPLY),
      .SYNC_STAGES  (SYNC)
   ) i_sync_responder (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (line_in),
      .drv_en  (drv_en),
      .drv_val (drv_val),
      .busy    (busy)
   );

   function automatic bit exp_reply(input int n);
      return n >= int'(DET);
   endfunction

   function automatic int exp_latency();
      return int'(SYNC + 1 + GUARD);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_trial(input int n, input bit glitch);
      int lat = 0, lows = 0, highs = 0, busyc = 0, bad_rel = 0, hold_drv = 0;
      bit prev_high = 1'b0;
      host_low = 1'b1;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (drv_en || busy) hold_drv++;
      end
      host_low = 1'b0;
      for (int i = 1; i <= int'(LIMIT); i++) begin
         @(negedge clk);
         if (drv_en && lat == 0) lat = i;
         if (drv_en && !drv_val) lows++;
         if (drv_en && drv_val) highs++;
         if (busy) busyc++;
         if (prev_high && drv_en) bad_rel++;
         prev_high = drv_en && drv_val;
         if (glitch) host_low = (i == 3) || (i == 10);
      end
      host_low = 1'b0;
      check("R4 no drive while line held low", hold_drv, 0);
      if (exp_reply(n)) begin
         check(glitch ? "R8 latency with glitch" : "R3/R5 reply latency", lat, exp_latency());
         check(glitch ? "R8 low length with glitch" : "R6 low length", lows, int'(REPLY));
         check("R7 one high cycle", highs, 1);
         check("R7 release after high", bad_rel, 0);
         check("R9 busy length", busyc, int'(GUARD + REPLY + 1));
      end else begin
         check("R2 short low no reply", lat, 0);
         check("R2 short low not busy", busyc, 0);
      end
      repeat (SYNC + 3) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 drv_en in reset", int'(drv_en), 0);
      check("R1 busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      run_trial(int'(DET) - 1, 1'b0);
      run_trial(int'(DET), 1'b0);
      run_trial(5 * int'(DET), 1'b0);
      run_trial(int'(DET) + 2, 1'b1);
      for (int t = 0; t < 40; t++) begin
         run_trial(int'($urandom_range(1, 3 * DET)), 1'($urandom_range(0, 1)));
      end
      host_low = 1'b1;
      repeat (DET + 2) @(negedge clk);
      host_low = 1'b0;
      repeat (SYNC + GUARD + 4) @(negedge clk);
      check("R6 driving low before mid reset", int'(drv_en), 1);
      rst_n = 1'b0;
      #1;
      check("R1 async release of pin", int'(drv_en), 0);
      check("R1 busy cleared", int'(busy), 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (LIMIT) @(negedge clk);
      check("R1 stays idle after reset", int'(busy), 0);
      done = 1'b1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (150000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule